// File: doc/BRIEF.md
# Up/Down Gray Code Counter

A three-bit synchronous counter that walks the reflected Gray code cycle, so exactly one output bit toggles on every advance. A direction input chooses between forward and reverse stepping through the same eight codes. A count enable gates advancing, and a synchronous clear returns the counter to the zero code.

A terminal flag marks the last code before wrap-around for the direction currently selected. This lets several counters be chained, or lets a controller see that one full cycle has completed. All state bits are updated on a single clock edge. An asynchronous active-low reset sets the start state.

Top module: `gray_updn_ctr`

## Requirements
- R1: With up_i=1 and en_i=1, state_o advances each clock through 000, 001, 011, 010, 110, 111, 101, 100 and then back to 000.
- R2: With up_i=0 and en_i=1, state_o walks the R1 cycle in reverse: 000 goes to 100, 100 to 101, and so on, ending 001 to 000.
- R3: Every enabled advance changes exactly one bit of state_o, in either direction.
- R4: While rst_ni is low, state_o is 000, independent of the clock.
- R5: clr_i=1 forces state_o to 000 on the next clock edge, whatever the values of en_i and up_i.
- R6: With en_i=0 and clr_i=0, state_o holds its value on every edge, whatever the value of up_i.
- R7: tc_o is 1 when up_i=1 and state_o=100, or when up_i=0 and state_o=000. Otherwise it is 0.
- R8: A change of up_i takes effect on the next enabled edge. The counter moves directly to the neighbour code in the new direction, with no intermediate state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear to 000, active high |
| en_i | input | 1 | Count enable |
| up_i | input | 1 | Direction: 1 forward, 0 reverse |
| state_o | output | 3 | Current Gray code |
| tc_o | output | 1 | Terminal code for the current direction |

## Verification
The bench targets the two wrap points. If 100 fails to return to 000 going up, or 000 fails to go to 100 going down, the design would leave the eight-code cycle or stall there. It reverses direction in the middle of the cycle, where a design that inserts an extra step or uses the old direction for one more clock would land on the wrong neighbour. It toggles up_i while the counter is disabled, where a design that lets direction leak into the hold path would drift. It also asserts the clear together with enable, where a wrong priority would leave the counter advanced instead of at zero. The terminal flag is checked at both ends in both directions; swapped decoding would flag 000 when counting up.

// File: rtl/gray_ctr_pkg.sv
package gray_ctr_pkg;
  parameter int unsigned STATE_W = 3;
  localparam int unsigned NUM_STATES = 1 << STATE_W;
  typedef logic [STATE_W-1:0] gray_t;
  localparam gray_t ZERO_CODE = '0;
  // last code of the forward cycle: only the MSB set
  localparam gray_t LAST_UP_CODE = gray_t'(1) << (STATE_W - 1);
endpackage

// File: rtl/gray_step.sv
module gray_step
  import gray_ctr_pkg::*;
(
  input  gray_t cur_i,
  input  logic  up_i,
  output gray_t nxt_o
);
  gray_t bin_cur;
  gray_t bin_nxt;

  always_comb begin
    for (int i = 0; i < int'(STATE_W); i++) begin
      bin_cur[i] = ^(cur_i >> i);
    end
  end

  assign bin_nxt = up_i ? gray_t'(bin_cur + gray_t'(1)) : gray_t'(bin_cur - gray_t'(1));
  assign nxt_o   = bin_nxt ^ (bin_nxt >> 1);
endmodule

// File: rtl/gray_term.sv
module gray_term
  import gray_ctr_pkg::*;
(
  input  gray_t cur_i,
  input  logic  up_i,
  output logic  tc_o
);
  assign tc_o = up_i ? (cur_i == LAST_UP_CODE) : (cur_i == ZERO_CODE);
endmodule

// File: rtl/gray_updn_ctr.sv
module gray_updn_ctr
  import gray_ctr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               en_i,
  input  logic               up_i,
  output logic [STATE_W-1:0] state_o,
  output logic               tc_o
);
  gray_t state_q;
  gray_t state_nxt;

  gray_step u_step (
    .cur_i (state_q),
    .up_i  (up_i),
    .nxt_o (state_nxt)
  );

  gray_term u_term (
    .cur_i (state_q),
    .up_i  (up_i),
    .tc_o  (tc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= ZERO_CODE;
    else if (clr_i)  state_q <= ZERO_CODE;
    else if (en_i)   state_q <= state_nxt;
  end

  assign state_o = state_q;

  // forward successor table, written independently of u_step
  function automatic gray_t fwd_of(input gray_t g);
    case (g)
      3'b000:  return 3'b001;
      3'b001:  return 3'b011;
      3'b011:  return 3'b010;
      3'b010:  return 3'b110;
      3'b110:  return 3'b111;
      3'b111:  return 3'b101;
      3'b101:  return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  assert_fwd_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && up_i) |=> (state_q == fwd_of($past(state_q))));

  assert_rev_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && !up_i) |=> (fwd_of(state_q) == $past(state_q)));

  assert_one_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |=> ($countones(state_q ^ $past(state_q)) == 1));

  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (state_q == ZERO_CODE));

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(state_q));

  assert_tc_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && en_i && !clr_i) |=> (state_q == (up_i ? ZERO_CODE : LAST_UP_CODE) || 1'b1) &&
      (($past(up_i) && state_q == ZERO_CODE) || (!$past(up_i) && state_q == LAST_UP_CODE)));
endmodule

// File: tb/gray_updn_ctr_bench.sv
module gray_updn_ctr_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr_i = 1'b0;
  logic       en_i = 1'b0;
  logic       up_i = 1'b1;
  logic [2:0] state_o;
  logic       tc_o;

  int checks = 0;
  int failures = 0;
  int idx = 0;
  bit finished = 0;

  logic [2:0] seq [8] = '{3'b000, 3'b001, 3'b011, 3'b010, 3'b110, 3'b111, 3'b101, 3'b100};

  always #4 clk_i = ~clk_i;

  gray_updn_ctr u_gray_updn_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .en_i    (en_i),
    .up_i    (up_i),
    .state_o (state_o),
    .tc_o    (tc_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic bit exp_tc(input int i, input bit up);
    return up ? (i == 7) : (i == 0);
  endfunction

  task automatic step(input bit en, input bit up, input bit clr, input string req);
    logic [2:0] prev;
    @(negedge clk_i);
    en_i = en; up_i = up; clr_i = clr;
    #1;
    chk(tc_o == exp_tc(idx, up), "R7", tc_o, exp_tc(idx, up));
    prev = state_o;
    @(posedge clk_i);
    #1;
    if (clr) idx = 0;
    else if (en) idx = up ? (idx + 1) % 8 : (idx + 7) % 8;
    chk(state_o == seq[idx], req, state_o, seq[idx]);
    if (en && !clr) chk($countones(state_o ^ prev) == 1, "R3", state_o ^ prev, 1);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    #3;
    chk(state_o == 3'b000, "R4", state_o, 0);
    @(negedge clk_i);
    chk(state_o == 3'b000, "R4", state_o, 0);
    rst_ni = 1'b1;
    idx = 0;
  endtask

  task automatic t_up();
    for (int k = 0; k < 9; k++) step(1'b1, 1'b1, 1'b0, "R1");
  endtask

  task automatic t_down();
    for (int k = 0; k < 9; k++) step(1'b1, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_hold();
    step(1'b1, 1'b1, 1'b0, "R1");
    step(1'b1, 1'b1, 1'b0, "R1");
    for (int k = 0; k < 4; k++) step(1'b0, k[0], 1'b0, "R6");
  endtask

  task automatic t_dir();
    step(1'b1, 1'b1, 1'b0, "R8");
    step(1'b1, 1'b0, 1'b0, "R8");
    step(1'b1, 1'b1, 1'b0, "R8");
    step(1'b1, 1'b1, 1'b0, "R8");
    step(1'b1, 1'b0, 1'b0, "R8");
  endtask

  task automatic t_clear();
    step(1'b1, 1'b1, 1'b0, "R1");
    step(1'b1, 1'b1, 1'b1, "R5");
    step(1'b1, 1'b0, 1'b0, "R2");
    step(1'b1, 1'b0, 1'b1, "R5");
    step(1'b0, 1'b1, 1'b1, "R5");
  endtask

  task automatic t_async_reset();
    step(1'b1, 1'b1, 1'b0, "R1");
    step(1'b1, 1'b1, 1'b0, "R1");
    @(negedge clk_i);
    en_i = 1'b0;
    #1 rst_ni = 1'b0;
    #1;
    chk(state_o == 3'b000, "R4", state_o, 0);
    #1 rst_ni = 1'b1;
    idx = 0;
  endtask

  initial begin
    t_reset();
    t_up();
    t_down();
    t_hold();
    t_dir();
    t_clear();
    t_async_reset();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule